// File: doc/BRIEF.md
# PAUSE Control Frame Receive Detector

This block watches the byte stream of a receiving Ethernet MAC and decides, frame by frame, whether the frame is a valid flow-control PAUSE request. It checks three things. The destination address must equal either a programmed control multicast address or the station's own unicast address. The two-byte type field must equal a programmed control type. The opcode must be the PAUSE opcode 0x0001. When the frame then ends with a good frame check sequence and receive-side pausing is enabled, the block raises a one-cycle strobe and presents the 16-bit pause quanta carried in the frame. A transmitter-side pause timer consumes these.

Software normally loads the control multicast register with 01-80-C2-00-00-01 and the type register with 0x8808. The station address register holds the port's primary unicast address. When the enable is cleared, the port still sends PAUSE frames of its own but ignores the ones it receives.

Header bytes are numbered from 0 in arrival order:

- Bytes 0–5 are the destination address.
- Bytes 6–11 are the source address, which is not checked.
- Bytes 12–13 are the type field.
- Bytes 14–15 are the opcode.
- Bytes 16–17 are the quanta.

Each multi-byte field arrives most significant byte first, so byte 0 is compared with bits 47:40 of an address register.

The control state machine uses these states:

- `ST_IDLE`: no frame is open.
- `ST_DEST`: the destination address bytes are arriving.
- `ST_SRC`: the source address bytes are arriving.
- `ST_TYPE`: the type bytes are arriving.
- `ST_OPCODE`: the opcode bytes are arriving.
- `ST_QUANTA`: the quanta bytes are arriving.
- `ST_PAYLOAD`: every byte after byte 17 until the frame ends.

Its transitions are:

- A start-of-frame byte moves any state to `ST_DEST`, unless that byte also ends the frame.
- The last byte of each header field advances the machine to the next field state.
- `ST_PAYLOAD` holds until the frame ends.
- An end-of-frame byte returns any state to `ST_IDLE`.

Top module: `pause_frame_detector`

## Requirements
- R1: After reset, `pause_det` is 0 and `pause_quanta` is 0x0000.
- R2: A frame whose destination bytes 0–5 equal `cfg_ctrl_addr` (byte 0 against bits 47:40, byte 5 against bits 7:0) passes the address check. A mismatch in any single one of these bytes fails the check, unless R3 applies.
- R3: A frame whose destination bytes equal `cfg_station_addr`, in the same byte order, also passes the address check. A frame that matches neither address is rejected. Source address bytes 6–11 never affect the decision.
- R4: Bytes 12 (bits 15:8) and 13 (bits 7:0) must equal `cfg_ctrl_type`, or the frame is rejected.
- R5: Bytes 14 and 15 must form the opcode 0x0001, most significant byte first, or the frame is rejected.
- R6: On detection, `pause_quanta` is {byte 16, byte 17}. The value holds unchanged until the next detection.
- R7: `pause_det` is high for exactly one cycle. That cycle is the one after the clock edge that takes the end-of-frame byte, and `rx_fcs_ok` must be 1 with that byte. A frame ending with `rx_fcs_ok` at 0 is rejected.
- R8: A frame whose end-of-frame byte has index below 17 is rejected. A frame ending exactly on byte 17, or later, may be accepted.
- R9: While `cfg_rx_pause_en` is 0, an otherwise valid frame raises no strobe and leaves `pause_quanta` unchanged.
- R10: A start-of-frame byte clears all mismatch history and restarts byte numbering, even in the middle of an open frame. A frame that follows a rejected one is judged on its own bytes.
- R11: Bytes arriving with `rx_valid` high but outside any open frame, and without `rx_sof`, are ignored. Cycles with `rx_valid` low do not advance the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_sof | input | 1 | This byte is byte 0 of a frame |
| rx_eof | input | 1 | This byte is the last byte of a frame |
| rx_fcs_ok | input | 1 | Frame check sequence good, qualified by `rx_eof` |
| rx_data | input | 8 | Received byte |
| cfg_ctrl_addr | input | 48 | Control multicast address |
| cfg_station_addr | input | 48 | Station unicast address |
| cfg_ctrl_type | input | 16 | Expected type field value |
| cfg_rx_pause_en | input | 1 | Act on received PAUSE frames |
| pause_det | output | 1 | One-cycle strobe: a valid PAUSE frame was received |
| pause_quanta | output | 16 | Quanta of the last detected frame |

## Verification
The assertions check, on every cycle, these temporal properties of the strobe:

- It follows an end-of-frame byte that carried a good FCS, while the enable was set.
- It never lasts two cycles.
- The quanta output moves only together with the strobe.

They also check that stray bytes outside a frame neither change the byte count nor open a frame, and that a start-of-frame byte leaves no type or opcode mismatch behind. Only the bench scenarios can show that the decision is right. These scenarios cover each of the 18 header bytes corrupted in turn under both destination kinds, every frame length around the runt limit, and restarts in the middle of a frame. In each case the expected accept or reject and the expected quanta are computed from the frame bytes.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Header layout, in byte index from the first byte of the frame
    localparam int MAC_BYTES  = 6;
    localparam int TYPE_BYTES = 2;
    localparam int OPC_BYTES  = 2;
    localparam int QNT_BYTES  = 2;

    localparam int DA_POS   = 0;
    localparam int SA_POS   = DA_POS + MAC_BYTES;
    localparam int TYPE_POS = SA_POS + MAC_BYTES;
    localparam int OPC_POS  = TYPE_POS + TYPE_BYTES;
    localparam int QNT_POS  = OPC_POS + OPC_BYTES;
    localparam int HDR_LAST = QNT_POS + QNT_BYTES - 1;
    localparam int IDX_SAT  = HDR_LAST + 1;

    localparam int IDX_W    = $clog2(IDX_SAT + 1);
    localparam int ADDR_W   = 8 * MAC_BYTES;
    localparam int TYPE_W   = 8 * TYPE_BYTES;
    localparam int OPC_W    = 8 * OPC_BYTES;
    localparam int QUANTA_W = 8 * QNT_BYTES;

    typedef logic [IDX_W-1:0] hdr_idx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEST,
        ST_SRC,
        ST_TYPE,
        ST_OPCODE,
        ST_QUANTA,
        ST_PAYLOAD
    } pfd_state_e;

    typedef struct packed {
        logic mc_miss;
        logic uc_miss;
        logic type_miss;
        logic op_miss;
    } pfd_miss_t;

endpackage

// File: rtl/pfd_byte_index.sv
module pfd_byte_index
    import pfd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rx_valid,
    input  logic     rx_sof,
    input  logic     in_frame,
    output hdr_idx_t cur_idx,
    output logic     byte_live
);

    localparam hdr_idx_t SAT = hdr_idx_t'(IDX_SAT);

    hdr_idx_t idx_q;

    // A byte belongs to a frame if it opens one or one is already open
    assign byte_live = rx_valid && (rx_sof || in_frame);
    assign cur_idx   = rx_sof ? '0 : idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (byte_live) begin
            idx_q <= (cur_idx == SAT) ? SAT : cur_idx + hdr_idx_t'(1);
        end
    end

    // R11: a stray byte outside a frame leaves the count alone
    p_stray_byte_ignored_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_sof && !in_frame) |=> $stable(idx_q));

endmodule

// File: rtl/pfd_hdr_match.sv
module pfd_hdr_match
    import pfd_pkg::*;
#(
    parameter logic [OPC_W-1:0] PAUSE_OPCODE = 16'h0001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_live,
    input  logic                rx_sof,
    input  hdr_idx_t            cur_idx,
    input  logic [7:0]          rx_data,
    input  logic [ADDR_W-1:0]   cfg_ctrl_addr,
    input  logic [ADDR_W-1:0]   cfg_station_addr,
    input  logic [TYPE_W-1:0]   cfg_ctrl_type,
    output pfd_miss_t           miss_next,
    output logic [QUANTA_W-1:0] quanta_next
);

    pfd_miss_t           miss_q;
    logic [QUANTA_W-1:0] quanta_q;
    logic [MAC_BYTES-1:0] mc_hit;
    logic [MAC_BYTES-1:0] uc_hit;

    // Per-byte comparators for both destination candidates
    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_addr_cmp
        assign mc_hit[g] = (rx_data == cfg_ctrl_addr[8*(MAC_BYTES-1-g) +: 8]);
        assign uc_hit[g] = (rx_data == cfg_station_addr[8*(MAC_BYTES-1-g) +: 8]);
    end

    always_comb begin
        miss_next   = rx_sof ? '0 : miss_q;
        quanta_next = quanta_q;
        if (byte_live) begin
            for (int i = 0; i < MAC_BYTES; i++) begin
                if (cur_idx == hdr_idx_t'(DA_POS + i)) begin
                    miss_next.mc_miss = miss_next.mc_miss | ~mc_hit[i];
                    miss_next.uc_miss = miss_next.uc_miss | ~uc_hit[i];
                end
            end
            for (int j = 0; j < TYPE_BYTES; j++) begin
                if (cur_idx == hdr_idx_t'(TYPE_POS + j)) begin
                    miss_next.type_miss = miss_next.type_miss |
                        (rx_data != cfg_ctrl_type[8*(TYPE_BYTES-1-j) +: 8]);
                end
            end
            for (int k = 0; k < OPC_BYTES; k++) begin
                if (cur_idx == hdr_idx_t'(OPC_POS + k)) begin
                    miss_next.op_miss = miss_next.op_miss |
                        (rx_data != PAUSE_OPCODE[8*(OPC_BYTES-1-k) +: 8]);
                end
            end
            for (int m = 0; m < QNT_BYTES; m++) begin
                if (cur_idx == hdr_idx_t'(QNT_POS + m)) begin
                    quanta_next[8*(QNT_BYTES-1-m) +: 8] = rx_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q   <= '0;
            quanta_q <= '0;
        end else if (byte_live) begin
            miss_q   <= miss_next;
            quanta_q <= quanta_next;
        end
    end

    // R10: a start-of-frame byte cannot leave a type or opcode mismatch behind
    p_sof_clears_history_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (byte_live && rx_sof) |=> (!miss_q.type_miss && !miss_q.op_miss));

endmodule

// File: rtl/pause_frame_detector.sv
module pause_frame_detector
    import pfd_pkg::*;
#(
    parameter logic [OPC_W-1:0] PAUSE_OPCODE = 16'h0001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_valid,
    input  logic                rx_sof,
    input  logic                rx_eof,
    input  logic                rx_fcs_ok,
    input  logic [7:0]          rx_data,
    input  logic [ADDR_W-1:0]   cfg_ctrl_addr,
    input  logic [ADDR_W-1:0]   cfg_station_addr,
    input  logic [TYPE_W-1:0]   cfg_ctrl_type,
    input  logic                cfg_rx_pause_en,
    output logic                pause_det,
    output logic [QUANTA_W-1:0] pause_quanta
);

    localparam hdr_idx_t DA_LAST   = hdr_idx_t'(SA_POS - 1);
    localparam hdr_idx_t SA_LAST   = hdr_idx_t'(TYPE_POS - 1);
    localparam hdr_idx_t TYPE_LAST = hdr_idx_t'(OPC_POS - 1);
    localparam hdr_idx_t OPC_LAST  = hdr_idx_t'(QNT_POS - 1);
    localparam hdr_idx_t QNT_LAST  = hdr_idx_t'(HDR_LAST);

    pfd_state_e          state_q, state_d;
    hdr_idx_t            cur_idx;
    logic                byte_live;
    logic                frame_end;
    logic                accept;
    pfd_miss_t           miss_next;
    logic [QUANTA_W-1:0] quanta_next;

    pfd_byte_index u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_sof    (rx_sof),
        .in_frame  (state_q != ST_IDLE),
        .cur_idx   (cur_idx),
        .byte_live (byte_live)
    );

    pfd_hdr_match #(.PAUSE_OPCODE(PAUSE_OPCODE)) u_match (
        .clk              (clk),
        .rst_n            (rst_n),
        .byte_live        (byte_live),
        .rx_sof           (rx_sof),
        .cur_idx          (cur_idx),
        .rx_data          (rx_data),
        .cfg_ctrl_addr    (cfg_ctrl_addr),
        .cfg_station_addr (cfg_station_addr),
        .cfg_ctrl_type    (cfg_ctrl_type),
        .miss_next        (miss_next),
        .quanta_next      (quanta_next)
    );

    assign frame_end = byte_live && rx_eof;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (frame_end) begin
            state_d = ST_IDLE;
        end else if (byte_live && rx_sof) begin
            state_d = ST_DEST;
        end else if (byte_live) begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_DEST:    if (cur_idx == DA_LAST)   state_d = ST_SRC;
                ST_SRC:     if (cur_idx == SA_LAST)   state_d = ST_TYPE;
                ST_TYPE:    if (cur_idx == TYPE_LAST) state_d = ST_OPCODE;
                ST_OPCODE:  if (cur_idx == OPC_LAST)  state_d = ST_QUANTA;
                ST_QUANTA:  if (cur_idx == QNT_LAST)  state_d = ST_PAYLOAD;
                ST_PAYLOAD: state_d = ST_PAYLOAD;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Frame decision at the last byte
    assign accept = frame_end && rx_fcs_ok && cfg_rx_pause_en
                 && (cur_idx >= QNT_LAST)
                 && !(miss_next.mc_miss && miss_next.uc_miss)
                 && !miss_next.type_miss
                 && !miss_next.op_miss;

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_det    <= 1'b0;
            pause_quanta <= '0;
        end else begin
            pause_det <= accept;
            if (accept) pause_quanta <= quanta_next;
        end
    end

    // R7: strobe only after an end-of-frame byte with good FCS
    p_det_after_good_eof_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        pause_det |-> $past(rx_valid && rx_eof && rx_fcs_ok));

    // R7: strobe lasts a single cycle
    p_det_single_cycle_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        pause_det |=> !pause_det);

    // R9: no strobe while receive pausing is disabled
    p_det_needs_enable_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        pause_det |-> $past(cfg_rx_pause_en));

    // R6: quanta move only with a detection
    p_quanta_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        !pause_det |-> $stable(pause_quanta));

    // R11: without a start-of-frame byte the idle state is kept
    p_idle_kept_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !(rx_valid && rx_sof)) |=> state_q == ST_IDLE);

endmodule

// File: tb/pause_frame_detector_bench.sv
module pause_frame_detector_bench;

    localparam logic [47:0] MC_ADDR = 48'h0180C2000001;
    localparam logic [47:0] ST_ADDR = 48'h0A1B2C3D4E5F;
    localparam logic [15:0] CTYPE   = 16'h8808;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_fcs_ok = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        cfg_en = 1'b1;
    logic        pause_det;
    logic [15:0] pause_quanta;

    int checks = 0;
    int errors = 0;
    logic [7:0]  fr [0:31];
    logic [15:0] exp_q = 16'h0000;

    always #5 clk = ~clk;

    pause_frame_detector u_pause_frame_detector (
        .clk              (clk),
        .rst_n            (rst_n),
        .rx_valid         (rx_valid),
        .rx_sof           (rx_sof),
        .rx_eof           (rx_eof),
        .rx_fcs_ok        (rx_fcs_ok),
        .rx_data          (rx_data),
        .cfg_ctrl_addr    (MC_ADDR),
        .cfg_station_addr (ST_ADDR),
        .cfg_ctrl_type    (CTYPE),
        .cfg_rx_pause_en  (cfg_en),
        .pause_det        (pause_det),
        .pause_quanta     (pause_quanta)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic build(input logic [47:0] da, input logic [15:0] ty,
                         input logic [15:0] op, input logic [15:0] q);
        for (int i = 0; i < 6; i++) fr[i] = da[8*(5-i) +: 8];
        for (int i = 6; i < 12; i++) fr[i] = 8'h20 + 8'(i);
        fr[12] = ty[15:8]; fr[13] = ty[7:0];
        fr[14] = op[15:8]; fr[15] = op[7:0];
        fr[16] = q[15:8];  fr[17] = q[7:0];
        for (int i = 18; i < 32; i++) fr[i] = 8'(i * 7);
    endtask

    function automatic bit model(input int len, input bit fcs);
        logic [47:0] da;
        for (int i = 0; i < 6; i++) da[8*(5-i) +: 8] = fr[i];
        return (len >= 18) && fcs && cfg_en && (da == MC_ADDR || da == ST_ADDR)
            && ({fr[12], fr[13]} == CTYPE) && ({fr[14], fr[15]} == 16'h0001);
    endfunction

    task automatic idle_inputs();
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_fcs_ok = 0; rx_data = 8'h00;
    endtask

    task automatic send(input int len, input bit fcs, input bit gaps, input string req);
        bit ed;
        ed = model(len, fcs);
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk); idle_inputs();
            end
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_data = fr[i]; rx_fcs_ok = fcs && (i == len - 1);
        end
        @(negedge clk);
        idle_inputs();
        if (ed) exp_q = {fr[16], fr[17]};
        chk({req, " strobe"}, {15'd0, pause_det}, {15'd0, ed});
        chk({req, " quanta"}, pause_quanta, exp_q);
        @(negedge clk);
        chk({req, " R7 one-cycle"}, {15'd0, pause_det}, 16'd0);
    endtask

    task automatic send_partial(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = 0; rx_data = 8'hC0 + 8'(i);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset strobe", {15'd0, pause_det}, 16'd0);
        chk("R1 reset quanta", pause_quanta, 16'h0000);

        // Baseline frames to each address kind
        build(MC_ADDR, CTYPE, 16'h0001, 16'h1357);
        send(24, 1, 0, "R2 multicast");
        build(ST_ADDR, CTYPE, 16'h0001, 16'h2468);
        send(24, 1, 0, "R3 unicast");

        // Corrupt each header byte in turn, for both destination kinds
        for (int d = 0; d < 2; d++) begin
            for (int b = 0; b < 18; b++) begin
                build(d == 0 ? MC_ADDR : ST_ADDR, CTYPE, 16'h0001, 16'h0100 + 16'(b));
                fr[b] = fr[b] ^ 8'h5A;
                if (b < 6)       send(24, 1, b[0], "R2 R3 dest byte");
                else if (b < 12) send(24, 1, b[0], "R3 source ignored");
                else if (b < 14) send(24, 1, b[0], "R4 type byte");
                else if (b < 16) send(24, 1, b[0], "R5 opcode byte");
                else             send(24, 1, b[0], "R6 quanta byte");
            end
        end

        // Mixed-address destination: first half multicast, second half station
        build({MC_ADDR[47:24], ST_ADDR[23:0]}, CTYPE, 16'h0001, 16'h7777);
        send(24, 1, 0, "R3 mixed address");

        // Length sweep around the runt limit
        for (int len = 1; len <= 22; len++) begin
            build(MC_ADDR, CTYPE, 16'h0001, 16'h4000 + 16'(len));
            send(len, 1, len[0], "R8 length");
        end

        // Bad FCS
        build(MC_ADDR, CTYPE, 16'h0001, 16'hBEEF);
        send(24, 0, 0, "R7 bad fcs");

        // Quanta extremes
        build(ST_ADDR, CTYPE, 16'h0001, 16'h0000); send(20, 1, 0, "R6 quanta zero");
        build(ST_ADDR, CTYPE, 16'h0001, 16'hFFFF); send(20, 1, 1, "R6 quanta max");
        build(MC_ADDR, CTYPE, 16'h0001, 16'h8001); send(18, 1, 0, "R6 quanta msb");

        // Enable cleared
        cfg_en = 1'b0;
        build(MC_ADDR, CTYPE, 16'h0001, 16'h5555);
        send(24, 1, 0, "R9 disabled");
        cfg_en = 1'b1;

        // Restart in the middle of a frame
        send_partial(9);
        build(MC_ADDR, CTYPE, 16'h0001, 16'h0A0A);
        send(24, 1, 0, "R10 mid-frame restart");
        build(ST_ADDR, 16'h1234, 16'h0001, 16'h0B0B);
        send(24, 1, 0, "R10 rejected frame");
        build(ST_ADDR, CTYPE, 16'h0001, 16'h0C0C);
        send(24, 1, 0, "R10 fresh after reject");

        // Stray bytes with no frame open
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = 0; rx_eof = (i == 19); rx_fcs_ok = (i == 19);
            rx_data = (i < 18) ? 8'(MC_ADDR >> (8 * (5 - (i % 6)))) : 8'h01;
        end
        @(negedge clk);
        idle_inputs();
        chk("R11 stray strobe", {15'd0, pause_det}, 16'd0);
        chk("R11 stray quanta", pause_quanta, exp_q);
        build(MC_ADDR, CTYPE, 16'h0001, 16'h0D0D);
        send(24, 1, 1, "R11 frame after strays");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule